// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block collects the interrupt causes of a 16550-compatible serial port and turns them into one request line and an identification code that software can read. Five causes are tracked as pending flags: a receive line error, a receive FIFO timeout, received data ready, an empty transmit holding stage, and a modem status change. The neighbouring receive, transmit and modem logic raise or drop these flags with one-cycle set and clear strobes. An enable register written by software masks the flags, and the highest-ranked surviving cause is encoded into the identification byte.

The request line is gated by the general-purpose modem output that boards use to connect the port to the interrupt controller. Two register accesses have side effects. A read of the identification register retires a transmit-empty cause, but only when that cause is the one being reported. A write to the enable register re-arms transmit-empty if the transmit FIFO is empty at that moment. When FIFO mode is active, enabling received-data interrupts also enables the timeout cause without a separate control bit.

Top module: `uart_irq_prio`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the enable readback is 0x00, no cause is pending, the identification byte reads 0x01 and irq is low.
- R2: A write to the enable register stores data bits 3:0 as the enables: bit0 received data, bit1 transmit empty, bit2 line error, bit3 modem status. The readback returns those four bits with bits 7:4 zero.
- R3: Causes rank from highest to lowest as line error, receive timeout, received data, transmit empty, modem status. The identification low nibble is 0x6, 0xC, 0x4, 0x2 and 0x0 for them, in that order, and 0x1 when none is enabled and pending. Bits 5:4 read zero.
- R4: A pending cause whose enable is clear is left out of selection, stays pending, and appears once it is enabled.
- R5: A read of the identification register clears a pending transmit-empty cause only when the nibble being read is 0x2. Any other reported value leaves it pending.
- R6: While fifo_on is high, identification bits 7:6 read as 1. While it is low, they read as 0.
- R7: An enable write with bit1 set while tx_fifo_empty is high makes transmit-empty pending. With tx_fifo_empty low, the write does not.
- R8: The timeout cause is enabled by an enable write with bit0 set while fifo_on is high. A write made while fifo_on is low, or with bit0 clear, disables it.
- R9: irq is high exactly when op2 is high and some enabled cause is pending. With op2 low, irq is low.
- R10: If a set strobe and a clear strobe for the same cause arrive in one cycle, the cause is pending afterwards. The strobe vector bit positions are 0 received data, 1 transmit empty, 2 line error, 3 modem status, 4 receive timeout.
- R11: A clear strobe alone removes its cause from the pending set in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 5 | One-cycle set strobes, one per cause |
| src_clr | input | 5 | One-cycle clear strobes, one per cause |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Data for the enable register write |
| en_rdata | output | 8 | Enable register readback |
| id_rd | input | 1 | Read strobe of the identification register (side effect only) |
| id_rdata | output | 8 | Identification byte |
| fifo_on | input | 1 | FIFO mode active |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| op2 | input | 1 | Modem output 2 level, gates irq |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take the strobe inputs to be single-cycle pulses from the neighbouring logic. They allow a set and a clear for the same cause in one cycle, and they allow an enable write and an identification read to coincide with any strobe. The checks on read clearing and re-arming exclude cycles where a set strobe or an enable write for transmit-empty competes. For that reason the stimulus never relies on a coincidence the properties leave out, except in the directed test of set-over-clear. The bench keeps fifo_on and op2 at stable levels for whole vectors and changes them only between cycles, as a register write would.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt priority logic.
// Assumes five causes; the vector positions below are relied on by the
// neighbouring receive, transmit and modem logic.
package uirq_pkg;
    localparam int NSRC   = 5;
    localparam int DW     = 8;
    localparam int EN_W   = 4;

    // cause positions in strobe, pending and enable vectors
    localparam int S_RXD  = 0;
    localparam int S_TXE  = 1;
    localparam int S_LERR = 2;
    localparam int S_MDM  = 3;
    localparam int S_TMO  = 4;

    // identification nibbles
    localparam logic [3:0] ID_LERR = 4'h6;
    localparam logic [3:0] ID_TMO  = 4'hC;
    localparam logic [3:0] ID_RXD  = 4'h4;
    localparam logic [3:0] ID_TXE  = 4'h2;
    localparam logic [3:0] ID_MDM  = 4'h0;
    localparam logic [3:0] ID_NONE = 4'h1;

    // priority rank, index 0 is highest
    typedef struct packed {
        logic [2:0] src;
        logic [3:0] code;
    } rank_t;

    function automatic rank_t rank_at(input int idx);
        rank_t r;
        case (idx)
            0: r = '{src: 3'(S_LERR), code: ID_LERR};
            1: r = '{src: 3'(S_TMO),  code: ID_TMO};
            2: r = '{src: 3'(S_RXD),  code: ID_RXD};
            3: r = '{src: 3'(S_TXE),  code: ID_TXE};
            default: r = '{src: 3'(S_MDM), code: ID_MDM};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
// Module: enable register with the implicit timeout enable.
// Assumes en_wr is a one-cycle strobe. Produces the five-bit enable mask and
// a re-arm pulse for transmit-empty when written while the TX FIFO is empty.
module uirq_enable_reg
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [DW-1:0]   en_wdata,
    input  logic            fifo_on,
    input  logic            tx_fifo_empty,
    output logic [NSRC-1:0] en_mask,
    output logic            txe_rearm,
    output logic [DW-1:0]   en_rdata
);
    logic [EN_W-1:0] en_q;
    logic            tmo_en_q;

    // register the software enables and the derived timeout enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            tmo_en_q <= 1'b0;
        end else if (en_wr) begin
            en_q     <= en_wdata[EN_W-1:0];
            tmo_en_q <= fifo_on & en_wdata[S_RXD];
        end
    end

    // assemble the mask, readback and re-arm pulse
    always_comb begin
        en_mask        = '0;
        en_mask[EN_W-1:0] = en_q;
        en_mask[S_TMO] = tmo_en_q;
        en_rdata       = {{(DW-EN_W){1'b0}}, en_q};
        txe_rearm      = en_wr & en_wdata[S_TXE] & tx_fifo_empty;
    end

    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_rdata[EN_W-1:0] == $past(en_wdata[EN_W-1:0])));

    assert_tmo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !fifo_on) |=> !en_mask[S_TMO]);
endmodule

// File: rtl/uirq_pending.sv
// Module: pending-cause latch.
// Assumes strobes are one-cycle pulses. Set wins over every clear source in
// the same cycle; the identification read retires transmit-empty only when
// txe_reported is high.
module uirq_pending
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic            id_rd,
    input  logic            txe_reported,
    input  logic            txe_rearm,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] pend_d;

    // next-state: clears first, then the read side effect, then all sets
    always_comb begin
        pend_d = pend_q & ~src_clr;
        if (id_rd && txe_reported) pend_d[S_TXE] = 1'b0;
        if (txe_rearm)             pend_d[S_TXE] = 1'b1;
        pend_d = pend_d | src_set;
    end

    // hold the pending flags
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend & $past(src_set)) == $past(src_set)));

    assert_clr_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr[S_MDM] && !src_set[S_MDM]) |=> !pend[S_MDM]);

    assert_read_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && txe_reported && !src_set[S_TXE] && !txe_rearm) |=> !pend[S_TXE]);

    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txe_rearm |=> pend[S_TXE]);
endmodule

// File: rtl/uirq_encoder.sv
// Module: fixed-rank priority encoder.
// Assumes the enabled-pending vector is registered upstream; output is
// purely combinational. Walks the rank list from lowest to highest so the
// highest enabled cause overwrites the result last.
module uirq_encoder
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] live,
    output logic [3:0]      code,
    output logic            any
);
    // pick the code of the highest-ranked live cause
    always_comb begin
        code = ID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[rank_at(i).src]) code = rank_at(i).code;
        end
        any = |live;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Module: top of the UART interrupt identification and priority logic.
// Assumes register strobes come from a bus decoder one cycle wide. The
// identification byte and irq are combinational from registered state.
module uart_irq_prio
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic            en_wr,
    input  logic [DW-1:0]   en_wdata,
    output logic [DW-1:0]   en_rdata,
    input  logic            id_rd,
    output logic [DW-1:0]   id_rdata,
    input  logic            fifo_on,
    input  logic            tx_fifo_empty,
    input  logic            op2,
    output logic            irq
);
    logic [NSRC-1:0] en_mask;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] live;
    logic            txe_rearm;
    logic [3:0]      code;
    logic            any;
    logic            txe_reported;

    uirq_enable_reg u_en (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .fifo_on(fifo_on), .tx_fifo_empty(tx_fifo_empty),
        .en_mask(en_mask), .txe_rearm(txe_rearm), .en_rdata(en_rdata)
    );

    uirq_pending u_pend (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .id_rd(id_rd), .txe_reported(txe_reported), .txe_rearm(txe_rearm),
        .pend(pend)
    );

    // mask pending causes with their enables
    always_comb live = pend & en_mask;

    uirq_encoder u_enc (.live(live), .code(code), .any(any));

    // form identification byte, report flag and gated request
    always_comb begin
        txe_reported = (code == ID_TXE);
        id_rdata     = {fifo_on, fifo_on, 2'b00, code};
        irq          = op2 & any;
    end

    assert_lerr_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[S_LERR] && en_mask[S_LERR]) |-> (id_rdata[3:0] == ID_LERR));

    assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en_mask) == '0) |-> (id_rdata[3:0] == ID_NONE));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op2 && id_rdata[3:0] != ID_NONE) |-> irq);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rdata[3:0] == ID_NONE) |-> !irq);
endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_set = '0;
    logic [4:0] src_clr = '0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic [7:0] en_rdata;
    logic       id_rd = 1'b0;
    logic [7:0] id_rdata;
    logic       fifo_on = 1'b0;
    logic       tx_fifo_empty = 1'b0;
    logic       op2 = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_prio u0 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .id_rd(id_rd), .id_rdata(id_rdata), .fifo_on(fifo_on),
        .tx_fifo_empty(tx_fifo_empty), .op2(op2), .irq(irq)
    );

    // vector: set[31:27] clr[26:22] wr[21] wdata[20:13] fifo[12] op2[11]
    //         rd[10] tfe[9] exp_id[8:1] exp_irq[0]
    localparam int NV = 21;
    localparam logic [31:0] VEC [NV] = '{
        {5'b00001,5'b00000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h01,1'b0}, // R4 masked
        {5'b00000,5'b00000,1'b1,8'hFF,1'b0,1'b1,1'b0,1'b0,8'h04,1'b1}, // R4 appears
        {5'b01000,5'b00000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h04,1'b1}, // R3 rx over mdm
        {5'b00100,5'b00000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h06,1'b1}, // R3 lerr top
        {5'b00000,5'b00100,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h04,1'b1}, // R11
        {5'b00000,5'b00001,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1}, // R3 mdm
        {5'b10000,5'b00000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1}, // R8 tmo off
        {5'b00000,5'b00000,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R9 op2 low
        {5'b00000,5'b01000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h01,1'b0}, // R9 none
        {5'b00000,5'b00000,1'b1,8'h01,1'b1,1'b1,1'b0,1'b0,8'hCC,1'b1}, // R8 R6
        {5'b00001,5'b00000,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hCC,1'b1}, // R3 tmo over rx
        {5'b00000,5'b10000,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hC4,1'b1}, // R11
        {5'b00000,5'b00000,1'b1,8'h03,1'b1,1'b1,1'b0,1'b1,8'hC4,1'b1}, // R7 arm
        {5'b00000,5'b00001,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hC2,1'b1}, // R7 tx shown
        {5'b00000,5'b00000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,8'hC1,1'b0}, // R5 retire
        {5'b00011,5'b00000,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hC4,1'b1}, // R3
        {5'b00000,5'b00000,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,8'hC4,1'b1}, // R5 rx read
        {5'b00000,5'b00001,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hC2,1'b1}, // R5 tx kept
        {5'b00010,5'b00010,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'hC2,1'b1}, // R10
        {5'b00000,5'b00000,1'b1,8'h01,1'b0,1'b1,1'b0,1'b0,8'h01,1'b0}, // R6 R8
        {5'b10000,5'b00000,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h01,1'b0}  // R8
    };
    localparam logic [7:0] VREQ [NV] = '{
        8'd4, 8'd4, 8'd3, 8'd3, 8'd11, 8'd3, 8'd8, 8'd9, 8'd9, 8'd8, 8'd3,
        8'd11, 8'd7, 8'd7, 8'd5, 8'd3, 8'd5, 8'd5, 8'd10, 8'd6, 8'd8
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic drop_strobes();
        src_set = '0; src_clr = '0; en_wr = 1'b0; id_rd = 1'b0; en_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        drop_strobes();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_en(input logic [7:0] d, input logic tfe);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = d; tx_fifo_empty = tfe;
        @(negedge clk);
        drop_strobes();
        tx_fifo_empty = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1 reset state
        check8("R1 id", id_rdata, 8'h01);
        check8("R1 en", en_rdata, 8'h00);
        check8("R1 irq", {7'b0, irq}, 8'h00);

        op2 = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src_set       = VEC[i][31:27];
            src_clr       = VEC[i][26:22];
            en_wr         = VEC[i][21];
            en_wdata      = VEC[i][20:13];
            fifo_on       = VEC[i][12];
            op2           = VEC[i][11];
            id_rd         = VEC[i][10];
            tx_fifo_empty = VEC[i][9];
            @(negedge clk);
            drop_strobes();
            tx_fifo_empty = 1'b0;
            check8($sformatf("R%0d id vec %0d", VREQ[i], i), id_rdata, VEC[i][8:1]);
            check8($sformatf("R%0d irq vec %0d", VREQ[i], i), {7'b0, irq}, {7'b0, VEC[i][0]});
        end

        // R2: upper bits dropped on readback
        write_en(8'hA5, 1'b0);
        check8("R2 readback", en_rdata, 8'h05);

        // R1 again after mid-run reset
        do_reset();
        check8("R1 id after reset", id_rdata, 8'h01);
        check8("R1 en after reset", en_rdata, 8'h00);

        // R7 negative: TX FIFO not empty, no re-arm
        fifo_on = 1'b0; op2 = 1'b1;
        write_en(8'h0A, 1'b0);
        check8("R7 no arm", id_rdata, 8'h01);
        write_en(8'h0A, 1'b1);
        check8("R7 arm", id_rdata, 8'h02);
        check8("R9 irq arm", {7'b0, irq}, 8'h01);

        // R5: read while tx reported, no other cause
        @(negedge clk); id_rd = 1'b1;
        @(negedge clk); drop_strobes();
        check8("R5 direct", id_rdata, 8'h01);

        // R6 with fifo on, nothing pending
        fifo_on = 1'b1;
        @(negedge clk);
        check8("R6 idle fifo", id_rdata, 8'hC1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule